// File: doc/BRIEF.md
# Temperature code sampler and Celsius converter

This block sits between an on-die temperature sensor and the logic that needs its reading. The sensor produces a 10-bit unsigned code and pulses an end-of-conversion strobe for a single clock whenever that code is fresh. The block latches the code on each strobe, keeps it steady until the next strobe, and raises a valid flag once a real reading has arrived.

From the held code the block also derives a signed temperature in whole degrees Celsius. It scales the code by 708, divides by 1024 by dropping the ten low bits, and subtracts 273. It also drives the sensor's enable and reset lines from a single policy input. When the policy input is low the sensor is held in reset, strobes are ignored, and the captured code and valid flag are cleared.

Top module: `tsense_capture`

## Requirements
- R1: While `rst` is high, and at the first sample after it, `code_o` is 0, `valid_o` is 0 and `temp_o` is -273 (the conversion of code 0).
- R2: When `sense_en` and `eoc` are both high at a rising clock edge, `code_o` takes the value of `code_i` at that edge and `valid_o` is 1 after that edge.
- R3: While `sense_en` is high and `eoc` is low, `code_o` keeps its value across the edge, whatever `code_i` does.
- R4: After each edge, `temp_o` equals floor(708 × C / 1024) − 273, where C is the `code_o` value held before that edge. The value lags `code_o` by one clock. Worked values: code 341 gives -38, 512 gives 81, 580 gives 128, 0 gives -273, and 1023 gives 434.
- R5: When `sense_en` is low at an edge, `code_o` and `valid_o` are 0 after it, and an `eoc` pulse at that edge has no effect.
- R6: `valid_o` rises only on an edge where `sense_en` and `eoc` are both high. Once high, it stays high until `sense_en` falls or `rst` is asserted.
- R7: `sensor_en_o` is high exactly when `sense_en` is high and `rst` is low. `sensor_rst_o` is its complement: high during `rst` or while `sense_en` is low.
- R8: `temp_o` is a 10-bit two's-complement value. Code 341 gives -38, which is 11_1101_1010.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sense_en | input | 1 | Sensor enable policy bit |
| eoc | input | 1 | End-of-conversion strobe from the sensor, one clock wide |
| code_i | input | 10 | Raw temperature code from the sensor |
| sensor_en_o | output | 1 | Enable to the sensor |
| sensor_rst_o | output | 1 | Reset to the sensor |
| code_o | output | 10 | Held temperature code |
| valid_o | output | 1 | Held code is a real reading |
| temp_o | output | 10 | Signed temperature in degrees Celsius |

## Verification
The properties assume that `eoc` and `sense_en` are single-clock synchronous levels, and that `code_i` is meaningful only on strobe cycles. They assume nothing about how far apart strobes are. The stimulus therefore changes `code_i` freely between strobes to show that the held value does not follow it. It fires strobes back to back and also with long gaps, pulses `eoc` while the policy bit is low, and toggles the policy bit and reset in the middle of a run. Codes are chosen to cover both ends of the 10-bit range, the three reference points, and pseudo-random values, so that the truncating divide is exercised on both sides of the zero crossing.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

    localparam int CODE_W  = 10;
    localparam int TEMP_W  = 10;
    localparam int SCALE   = 708;
    localparam int FRAC_W  = 10;
    localparam int OFFSET  = 273;
    localparam int PROD_W  = CODE_W + FRAC_W;

    typedef logic [CODE_W-1:0]        code_t;
    typedef logic signed [TEMP_W-1:0] temp_t;

    typedef struct packed {
        logic  valid;
        code_t code;
    } sample_t;

    localparam sample_t SAMPLE_IDLE = '{valid: 1'b0, code: '0};

    function automatic temp_t to_celsius(input code_t c);
        logic [PROD_W-1:0] prod;
        logic [PROD_W-1:0] whole;
        int                deg;
        prod  = PROD_W'(c) * PROD_W'(SCALE);
        whole = prod >> FRAC_W;
        deg   = int'(whole) - OFFSET;
        return temp_t'(deg);
    endfunction

endpackage

// File: rtl/tsc_policy.sv
module tsc_policy (
    input  logic rst,
    input  logic sense_en,
    output logic sensor_en,
    output logic sensor_rst
);
    always_comb begin
        sensor_en  = sense_en & ~rst;
        sensor_rst = rst | ~sense_en;
    end
endmodule

// File: rtl/tsc_capture.sv
module tsc_capture
    import tsc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    enable,
    input  logic    strobe,
    input  code_t   raw,
    output sample_t held
);
    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            held <= SAMPLE_IDLE;
        end else if (strobe) begin
            held.code  <= raw;
            held.valid <= 1'b1;
        end
    end
endmodule

// File: rtl/tsc_convert.sv
module tsc_convert
    import tsc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  code_t code,
    output temp_t degrees
);
    temp_t next_deg;

    always_comb next_deg = to_celsius(code);

    always_ff @(posedge clk) begin
        if (rst) degrees <= to_celsius('0);
        else     degrees <= next_deg;
    end
endmodule

// File: rtl/tsense_capture.sv
module tsense_capture
    import tsc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        sense_en,
    input  logic        eoc,
    input  logic [9:0]  code_i,
    output logic        sensor_en_o,
    output logic        sensor_rst_o,
    output logic [9:0]  code_o,
    output logic        valid_o,
    output logic signed [9:0] temp_o
);
    sample_t held;
    temp_t   deg;

    tsc_policy u_policy (
        .rst        (rst),
        .sense_en   (sense_en),
        .sensor_en  (sensor_en_o),
        .sensor_rst (sensor_rst_o)
    );

    tsc_capture u_capture (
        .clk    (clk),
        .rst    (rst),
        .enable (sense_en),
        .strobe (eoc),
        .raw    (code_i),
        .held   (held)
    );

    tsc_convert u_convert (
        .clk     (clk),
        .rst     (rst),
        .code    (held.code),
        .degrees (deg)
    );

    assign code_o  = held.code;
    assign valid_o = held.valid;
    assign temp_o  = deg;
endmodule

// File: rtl/tsense_capture_chk.sv
module tsense_capture_chk (
    input logic        clk,
    input logic        rst,
    input logic        sense_en,
    input logic        eoc,
    input logic [9:0]  code_i,
    input logic        sensor_en_o,
    input logic        sensor_rst_o,
    input logic [9:0]  code_o,
    input logic        valid_o,
    input logic signed [9:0] temp_o
);
    assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
        (sense_en && eoc) |=> (code_o == $past(code_i)) && valid_o);

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (sense_en && !eoc) |=> $stable(code_o) && $stable(valid_o));

    assert_temp_follows_R4: assert property (@(posedge clk) disable iff (rst)
        $stable(code_o) |=> $stable(temp_o));

    assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
        !sense_en |=> (code_o == 10'd0) && !valid_o);

    assert_valid_rise_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(valid_o) |-> $past(sense_en && eoc));

    assert_sensor_off_R7: assert property (@(posedge clk)
        (rst || !sense_en) |-> (sensor_rst_o && !sensor_en_o));

    assert_sensor_on_R7: assert property (@(posedge clk)
        (!rst && sense_en) |-> (sensor_en_o && !sensor_rst_o));
endmodule

bind tsense_capture tsense_capture_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .sense_en     (sense_en),
    .eoc          (eoc),
    .code_i       (code_i),
    .sensor_en_o  (sensor_en_o),
    .sensor_rst_o (sensor_rst_o),
    .code_o       (code_o),
    .valid_o      (valid_o),
    .temp_o       (temp_o)
);

// File: tb/sim_tsense_capture.sv
`timescale 1ns/1ps
module sim_tsense_capture;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sense_en = 1'b0;
    logic        eoc = 1'b0;
    logic [9:0]  code_i = '0;
    logic        sensor_en_o, sensor_rst_o, valid_o;
    logic [9:0]  code_o;
    logic signed [9:0] temp_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    int exp_code  = 0;
    int exp_valid = 0;
    int exp_temp  = -273;

    always #2 clk = ~clk;

    tsense_capture u0 (
        .clk(clk), .rst(rst), .sense_en(sense_en), .eoc(eoc), .code_i(code_i),
        .sensor_en_o(sensor_en_o), .sensor_rst_o(sensor_rst_o),
        .code_o(code_o), .valid_o(valid_o), .temp_o(temp_o)
    );

    function automatic int deg_of(input int c);
        return (c * 708) / 1024 - 273;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference, advanced on every rising edge
    always @(posedge clk) begin
        if (rst) begin
            exp_code = 0; exp_valid = 0; exp_temp = deg_of(0);
        end else begin
            exp_temp = deg_of(exp_code);
            if (!sense_en) begin
                exp_code = 0; exp_valid = 0;
            end else if (eoc) begin
                exp_code = int'(code_i); exp_valid = 1;
            end
        end
    end

    // compare away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            check(int'(code_o) == exp_code, "R2/R3/R5 code", int'(code_o), exp_code);
            check(int'(valid_o) == exp_valid, "R6 valid", int'(valid_o), exp_valid);
            check(int'(temp_o) == exp_temp, "R4 temp", int'(temp_o), exp_temp);
            check(sensor_en_o == (sense_en && !rst), "R7 sensor enable",
                  int'(sensor_en_o), int'(sense_en && !rst));
            check(sensor_rst_o == (rst || !sense_en), "R7 sensor reset",
                  int'(sensor_rst_o), int'(rst || !sense_en));
        end
    end

    task automatic cyc(input bit en, input bit st, input int c);
        @(posedge clk); #1;
        sense_en = en; eoc = st; code_i = 10'(c);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(sense_en, 1'b0, int'($urandom_range(0, 1023)));
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic convert_point(input int c, input int want, input string req);
        cyc(1'b1, 1'b1, c);
        cyc(1'b1, 1'b0, 0);
        @(posedge clk); #1;
        @(negedge clk);
        check(int'(temp_o) == want, req, int'(temp_o), want);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog expired t=%0t", $time);
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: reset values
        check(code_o == 10'd0 && !valid_o, "R1 reset code/valid", int'(code_o), 0);
        check(int'(temp_o) == -273, "R1 reset temp", int'(temp_o), -273);
        cyc(1'b0, 1'b0, 0);
        rst = 1'b0;
        idle(3);
        // R5: strobe ignored while disabled
        cyc(1'b0, 1'b1, 777);
        cyc(1'b0, 1'b0, 0);
        @(negedge clk);
        check(code_o == 10'd0 && !valid_o, "R5 eoc ignored when disabled", int'(code_o), 0);
        // R2, R3, R6: enable, capture, hold
        cyc(1'b1, 1'b0, 55);
        idle(3);
        cyc(1'b1, 1'b1, 300);
        idle(6);
        @(negedge clk);
        check(code_o == 10'd300 && valid_o, "R3 hold after capture", int'(code_o), 300);
        // R4, R8: reference points and range ends
        convert_point(341, -38, "R8 code 341 two's complement");
        check(temp_o == 10'sb11_1101_1010, "R8 bit pattern", int'(temp_o), -38);
        convert_point(512, 81, "R4 code 512");
        convert_point(580, 128, "R4 code 580");
        convert_point(0, -273, "R4 code 0");
        convert_point(1023, 434, "R4 code 1023");
        // back-to-back strobes
        for (int i = 0; i < 20; i++) cyc(1'b1, 1'b1, int'($urandom_range(0, 1023)));
        // R5 then R6: disable clears, re-enable needs a strobe
        cyc(1'b0, 1'b0, 9);
        cyc(1'b1, 1'b0, 9);
        @(negedge clk);
        check(!valid_o && code_o == 10'd0, "R6 valid low after re-enable", int'(valid_o), 0);
        cyc(1'b1, 1'b1, 128);
        idle(2);
        // R1: reset mid-run
        @(posedge clk); #1; rst = 1'b1;
        idle(3);
        @(posedge clk); #1; rst = 1'b0;
        // mixed random traffic
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = int'($urandom_range(0, 99));
            cyc(r < 95, r < 30 || r > 96, int'($urandom_range(0, 1023)));
            if (r == 50) begin
                @(posedge clk); #1; rst = 1'b1;
                @(posedge clk); #1; rst = 1'b0;
            end
        end
        idle(3);
        finish_run();
    end
endmodule